// File: doc/BRIEF.md
# Instruction Fetch Burst Sequencer

This block fetches script instructions from system memory through a simple bus master port that can burst. For each instruction it raises a bus request and waits for a grant. It then issues one access command per ownership and collects the returning longwords. The instruction class comes from the top three bits of the first longword, decoded on the beat that carries that longword. That decode decides whether a further ownership is needed and how many beats it carries. The finished instruction of two, three or four longwords is held at the output under a valid/ready handshake until the downstream decoder takes it.

A single configuration input chooses between two fetch modes. In burst mode the first two longwords always arrive together as one two-beat burst. In single-beat mode every longword has an ownership of its own. The sequencer never fetches ahead of the instruction it is assembling, so it has no prefetch path. Fetch addresses start at the instruction pointer and step by 4 bytes. After each instruction is accepted, the pointer moves forward by the length of that instruction.

Top module: `ifetch_burst_seq`

## Requirements
- R1: While rstN is low, busReq, cmdValid and outValid are 0. The first command after reset targets address RESET_IP.
- R2: With burstEn = 1, the first ownership of every instruction carries exactly one command, with busBurst = 1 (two beats) and cmdAddr equal to the instruction pointer.
- R3: If bits [31:29] of the first longword are 3'b110 (memory-to-memory move) or 3'b101 (indirect), the instruction is 3 longwords long. With burstEn = 1 it takes one further ownership, a single beat (busBurst = 0) at pointer + 8.
- R4: If bits [31:29] are 3'b111 (table indirect move), the instruction is 4 longwords long. With burstEn = 1 it takes one further ownership, a two-beat burst at pointer + 8.
- R5: Any other value of bits [31:29] gives a 2-longword instruction that uses no ownership beyond the first.
- R6: With burstEn = 0, each longword k of the instruction is fetched in its own ownership, as a single beat at pointer + 4k.
- R7: A command is issued only while busReq and busGnt are both high, and at most once per ownership. Between two ownerships busReq falls for at least one cycle.
- R8: While outValid = 1 and outReady = 0, outValid stays high and outWords and outLen stay unchanged. busReq stays low the whole time outValid is high.
- R9: outLen gives the instruction length in longwords. Longword k sits at outWords[32k+31:32k], and slots at or beyond outLen read 0. Once the instruction is accepted, the pointer advances by 4 × outLen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| burstEn | input | 1 | 1 selects burst fetch, 0 selects single-beat fetch |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus ownership grant |
| cmdValid | output | 1 | One-cycle access command strobe |
| cmdAddr | output | AW | Byte address of the first beat of the command |
| busBurst | output | 1 | 1 = two-beat burst, 0 = single beat (valid with cmdValid) |
| rdValid | input | 1 | Read data beat valid |
| rdData | input | DW | Read data longword |
| outValid | output | 1 | Assembled instruction valid |
| outReady | input | 1 | Decoder accepts the instruction |
| outWords | output | 4*DW | Assembled longwords, slot 0 in the low bits |
| outLen | output | 3 | Instruction length in longwords (2 to 4) |

## Verification
Two events can land in the same cycle: the class decode and the ownership decision. The beat that delivers the first longword is also the beat that decides whether this ownership ends the instruction or a new request must follow. In single-beat mode that beat is also the last beat of its ownership. The bench provokes this by sweeping instruction pointers across all four opcode classes in both modes, with varied grant delays, data latencies and gaps between beats. A behavioural model predicts the exact sequence of command address and burst length for each instruction. Any command whose address or burst length differs from the model, any extra command and any missing command is reported.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int OPC_W  = 3;
  localparam int MAX_LW = 4;

  localparam logic [OPC_W-1:0] OPC_MEMMOVE  = 3'b110;
  localparam logic [OPC_W-1:0] OPC_INDIRECT = 3'b101;
  localparam logic [OPC_W-1:0] OPC_TABLE    = 3'b111;

  typedef struct packed {
    logic capture;
    logic latchLen;
    logic accept;
  } dpStrobe_t;

  function automatic logic [2:0] classLen(input logic [OPC_W-1:0] op);
    case (op)
      OPC_MEMMOVE, OPC_INDIRECT: classLen = 3'd3;
      OPC_TABLE:                 classLen = 3'd4;
      default:                   classLen = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/ifetch_dpath.sv
module ifetch_dpath
  import ifetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [1:0]           slotIdx,
  input  logic [DW-1:0]        rdData,
  output logic [2:0]           decLen,
  output logic [2:0]           instLen,
  output logic [AW-1:0]        cmdAddr,
  output logic [MAX_LW*DW-1:0] outWords,
  output logic [2:0]           outLen
);
  localparam int OPC_LSB = DW - OPC_W;

  logic [AW-1:0] ipReg;
  logic [2:0]    lenReg;
  logic [DW-1:0] slot [MAX_LW];

  assign decLen  = classLen(rdData[DW-1:OPC_LSB]);
  assign instLen = lenReg;
  assign outLen  = lenReg;
  assign cmdAddr = ipReg + AW'({slotIdx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ipReg  <= RESET_IP;
      lenReg <= 3'd2;
    end else begin
      if (strobe.latchLen) lenReg <= decLen;
      if (strobe.accept)   ipReg  <= ipReg + AW'({lenReg, 2'b00});
    end
  end

  for (genvar g = 0; g < MAX_LW; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.accept) slot[g] <= '0;
      else if (strobe.capture && slotIdx == 2'(g)) slot[g] <= rdData;
    end
    assign outWords[g*DW +: DW] = slot[g];
  end
endmodule

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstEn,
  input  logic       busGnt,
  input  logic       rdValid,
  input  logic       outReady,
  input  logic [2:0] decLen,
  input  logic [2:0] instLen,
  output logic       busReq,
  output logic       cmdValid,
  output logic       busBurst,
  output logic       outValid,
  output logic [1:0] slotIdx,
  output dpStrobe_t  strobe
);
  typedef enum logic [2:0] {S_GAP, S_REQ, S_CMD, S_DATA, S_HOLD} state_t;

  state_t     state;
  logic [2:0] lwIdx;
  logic [1:0] beatsLeft;
  logic [2:0] lenNow;
  logic [2:0] remain;

  always_comb begin
    lenNow          = (lwIdx == 3'd0) ? decLen : instLen;
    remain          = instLen - lwIdx;
    busBurst        = burstEn && ((lwIdx == 3'd0) || (remain >= 3'd2));
    busReq          = (state == S_REQ) || (state == S_CMD) || (state == S_DATA);
    cmdValid        = (state == S_CMD);
    outValid        = (state == S_HOLD);
    slotIdx         = lwIdx[1:0];
    strobe.capture  = (state == S_DATA) && rdValid;
    strobe.latchLen = strobe.capture && (lwIdx == 3'd0);
    strobe.accept   = outValid && outReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_GAP;
      lwIdx     <= 3'd0;
      beatsLeft <= 2'd0;
    end else begin
      case (state)
        S_GAP: state <= S_REQ;
        S_REQ: if (busGnt) state <= S_CMD;
        S_CMD: begin
          beatsLeft <= busBurst ? 2'd2 : 2'd1;
          state     <= S_DATA;
        end
        S_DATA: if (rdValid) begin
          lwIdx     <= lwIdx + 3'd1;
          beatsLeft <= beatsLeft - 2'd1;
          if (beatsLeft == 2'd1)
            state <= (lwIdx + 3'd1 == lenNow) ? S_HOLD : S_GAP;
        end
        S_HOLD: if (outReady) begin
          lwIdx <= 3'd0;
          state <= S_REQ;
        end
        default: state <= S_GAP;
      endcase
    end
  end
endmodule

// File: rtl/ifetch_burst_seq.sv
module ifetch_burst_seq
  import ifetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] RESET_IP = 32'h0000_1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 burstEn,
  output logic                 busReq,
  input  logic                 busGnt,
  output logic                 cmdValid,
  output logic [AW-1:0]        cmdAddr,
  output logic                 busBurst,
  input  logic                 rdValid,
  input  logic [DW-1:0]        rdData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [MAX_LW*DW-1:0] outWords,
  output logic [2:0]           outLen
);
  dpStrobe_t  strobe;
  logic [1:0] slotIdx;
  logic [2:0] decLen;
  logic [2:0] instLen;

  ifetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .busGnt(busGnt),
    .rdValid(rdValid), .outReady(outReady), .decLen(decLen), .instLen(instLen),
    .busReq(busReq), .cmdValid(cmdValid), .busBurst(busBurst),
    .outValid(outValid), .slotIdx(slotIdx), .strobe(strobe)
  );

  ifetch_dpath #(.AW(AW), .DW(DW), .RESET_IP(RESET_IP)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotIdx(slotIdx), .rdData(rdData),
    .decLen(decLen), .instLen(instLen), .cmdAddr(cmdAddr),
    .outWords(outWords), .outLen(outLen)
  );
endmodule

// File: rtl/ifetch_burst_seq_chk.sv
module ifetch_burst_seq_chk
  import ifetch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 burstEn,
  input logic                 busReq,
  input logic                 busGnt,
  input logic                 cmdValid,
  input logic [AW-1:0]        cmdAddr,
  input logic                 busBurst,
  input logic                 rdValid,
  input logic [DW-1:0]        rdData,
  input logic                 outValid,
  input logic                 outReady,
  input logic [MAX_LW*DW-1:0] outWords,
  input logic [2:0]           outLen
);
  p_cmd_granted_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (busReq && busGnt));

  p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_single_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !burstEn) |-> !busBurst);

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWords) && $stable(outLen)));

  p_no_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busReq);

  p_len_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLen >= 3'd2 && outLen <= 3'd4));

  p_no_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> !cmdValid);
endmodule

bind ifetch_burst_seq ifetch_burst_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ifetch_burst_seq_bench.sv
`timescale 1ns/1ps
module ifetch_burst_seq_bench;
  localparam logic [31:0] RIP = 32'h0000_1000;

  logic         clk = 0;
  logic         rstN, burstEn, busReq, busGnt, cmdValid, busBurst, rdValid;
  logic [31:0]  cmdAddr, rdData;
  logic         outValid, outReady;
  logic [127:0] outWords;
  logic [2:0]   outLen;

  always #2 clk = ~clk;

  ifetch_burst_seq #(.AW(32), .DW(32), .RESET_IP(RIP)) u_ifetch_burst_seq (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .busReq(busReq), .busGnt(busGnt),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .busBurst(busBurst),
    .rdValid(rdValid), .rdData(rdData), .outValid(outValid), .outReady(outReady),
    .outWords(outWords), .outLen(outLen)
  );

  typedef struct { logic [31:0] addr; logic burst; string tag; } cmd_t;
  cmd_t expQ[$];
  int tests = 0, fails = 0;
  int gapMode = 0;
  logic [31:0] mIp;
  bit firstCmd;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [2:0] op;
    op = a[4:2] ^ a[7:5] ^ a[10:8] ^ a[13:11];
    return {op, a[28:0] ^ 29'h15A5A5A};
  endfunction

  function automatic int lenOf(input logic [2:0] op);
    if (op == 3'b110 || op == 3'b101) return 3;
    if (op == 3'b111) return 4;
    return 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic pushCmd(input logic [31:0] a, input logic b, input string t);
    cmd_t c;
    c.addr = a; c.burst = b; c.tag = firstCmd ? "R1" : t;
    firstCmd = 0;
    expQ.push_back(c);
  endtask

  task automatic genCmds();
    int len;
    len = lenOf(memWord(mIp)[31:29]);
    if (burstEn) begin
      pushCmd(mIp, 1'b1, "R2");
      if (len == 3) pushCmd(mIp + 32'd8, 1'b0, "R3");
      if (len == 4) pushCmd(mIp + 32'd8, 1'b1, "R4");
    end else begin
      for (int k = 0; k < len; k++) pushCmd(mIp + 32'(4*k), 1'b0, "R6");
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // bus responder
  initial begin
    int gcnt, pend, dcnt, ownN;
    logic [31:0] raddr;
    busGnt = 0; rdValid = 0; rdData = 0;
    gcnt = 0; pend = 0; dcnt = 0; ownN = 0; raddr = 0;
    forever begin
      @(negedge clk);
      if (!busReq) begin
        if (busGnt) ownN++;
        busGnt = 0; gcnt = 0;
      end else if (!busGnt) begin
        gcnt++;
        if (gcnt >= 1 + (ownN % 3)) busGnt = 1;
      end
      rdValid = 0;
      if (pend > 0) begin
        if (dcnt > 0) dcnt--;
        else begin
          rdValid = 1; rdData = memWord(raddr); raddr += 32'd4; pend--; dcnt = gapMode;
        end
      end
      if (cmdValid) begin
        pend = busBurst ? 2 : 1; raddr = cmdAddr; dcnt = ownN % 2;
      end
    end
  end

  // command and hold monitor
  initial begin
    int ownCmds;
    cmd_t e;
    ownCmds = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!busReq) ownCmds = 0;
        if (outValid) chk(!busReq, "R8", "request while holding", 128'(busReq), 128'(0));
        if (cmdValid) begin
          chk(busGnt, "R7", "command without grant", 128'(busGnt), 128'(1));
          chk(ownCmds == 0, "R7", "second command in ownership", 128'(ownCmds), 128'(0));
          ownCmds++;
          if (expQ.size() == 0) chk(0, "R7", "unexpected command", 128'(cmdAddr), 128'(0));
          else begin
            e = expQ.pop_front();
            chk(cmdAddr == e.addr, e.tag, "command address", 128'(cmdAddr), 128'(e.addr));
            chk(busBurst == e.burst, e.tag, "burst length", 128'(busBurst), 128'(e.burst));
          end
        end
      end
    end
  end

  task automatic serve(input int stall, input logic nextBurst);
    logic [127:0] cap, expW;
    logic [2:0] capLen;
    int len;
    string t;
    do @(negedge clk); while (!outValid);
    cap = outWords; capLen = outLen;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(outValid && outWords == cap && outLen == capLen, "R8", "hold stability",
          outWords, cap);
    end
    len = lenOf(memWord(mIp)[31:29]);
    t = (len == 2) ? "R5" : (len == 3) ? "R3" : "R4";
    expW = '0;
    for (int k = 0; k < len; k++) expW[k*32 +: 32] = memWord(mIp + 32'(4*k));
    chk(outLen == 3'(len), t, "instruction length", 128'(outLen), 128'(len));
    chk(outWords[63:0] == expW[63:0], t, "first two longwords", outWords, expW);
    chk(outWords[127:64] == expW[127:64], "R9", "upper slots", outWords, expW);
    chk(expQ.size() == 0, burstEn ? "R2" : "R6", "commands left over",
        128'(expQ.size()), 128'(0));
    burstEn = nextBurst;
    outReady = 1;
    mIp = mIp + 32'(4*len);
    genCmds();
    @(negedge clk);
    outReady = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    logic modes [3];
    modes[0] = 1; modes[1] = 0; modes[2] = 1;
    rstN = 0; burstEn = 1; outReady = 0; mIp = RIP; firstCmd = 1;
    genCmds();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busReq && !cmdValid && !outValid, "R1", "outputs in reset",
          128'({busReq, cmdValid, outValid}), 128'(0));
    end
    rstN = 1;
    for (int ph = 0; ph < 3; ph++) begin
      gapMode = (ph == 2) ? 1 : 0;
      for (int n = 0; n < 60; n++)
        serve((n % 4 == 3) ? 3 : 0, (n == 59 && ph < 2) ? modes[ph+1] : modes[ph]);
    end
    repeat (4) @(negedge clk);
    summary();
  end
endmodule